// File: doc/BRIEF.md
# Hardware Cursor Pattern Overlay

This block draws a 64x64 hardware cursor on top of a raster of 8-bit indexed pixels. The cursor image sits in video memory with two bits per pixel. Before each raster line, the display controller pulses `line_go` and gives the row number it is about to show. If that row falls inside the cursor rectangle, the block reads the 16 pattern bytes for that row through a byte-wide read port into a staging buffer. When all 16 bytes have arrived, it copies them into the buffer that the display uses.

While the line is being displayed, every pixel inside the cursor rectangle is replaced by one of four values: the background colour, the foreground colour, the screen pixel, or the bitwise inverse of the screen pixel. The two-bit code selects the value, and two mapping modes are available. Pixels outside the rectangle pass through unchanged. So do all pixels when the cursor is off or the display is not in a graphics mode. The output is registered, and the timing strobes are delayed by the same single stage.

The pattern read port is a valid/ready request channel. The block holds an address until the memory takes it, and the memory returns one byte per accepted request, in order, on `mem_rsp_valid`. The pixel stream cannot be stalled, because raster timing does not wait, so it carries a valid strobe but no ready.

Top module: `cur_overlay`

## Requirements
- R1: While reset is held, `out_valid`, `out_late`, `mem_req_valid` and `fetch_busy` are all 0.
- R2: For a `line_go` whose `line_y` lies inside the cursor rows, the block issues exactly 16 reads at addresses base*1024 + row*16 + k, for k = 0..15 in increasing order. Here row = line_y - org_y + off_y, and addresses are taken modulo 2^ADDR_W. No reads are issued for rows outside the cursor, or when `cur_en` or `gfx_mode` is 0.
- R3: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid and its address does not change.
- R4: With `x11_mode`=0, the code {A,B} selects the output as follows: 00 gives `bg_col`, 01 gives `fg_col`, 10 gives the screen pixel, and 11 gives the bitwise inverse of the screen pixel. A is the high bit of the code.
- R5: With `x11_mode`=1, codes 00 and 01 give the screen pixel, 10 gives `bg_col`, and 11 gives `fg_col`.
- R6: When `cur_en`=0 or `gfx_mode`=0, `out_pix` equals the input pixel.
- R7: The overlay covers columns org_x up to org_x+64-off_x-1, and lines org_y up to org_y+64-off_y-1. Screen pixel (org_x+i, org_y+j) shows pattern pixel (off_x+i, off_y+j). All other pixels pass through.
- R8: Pattern pixel 16g+j of a row takes bit A from bit 15-j of the word formed by row bytes 4g (high) and 4g+1 (low). It takes bit B from the same bit of the word formed by bytes 4g+2 (high) and 4g+3 (low).
- R9: `out_valid`, `out_pix`, `out_hsync` and `out_vsync` follow the inputs with exactly one cycle of latency.
- R10: If a fetch is still running when the pixel at column org_x of a cursor line arrives, `out_late` is 1 together with that pixel's output. The whole line then uses the previous pattern row, and the late data is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Active pixel strobe |
| in_x | input | 11 | Column of the incoming pixel |
| in_pix | input | 8 | Incoming indexed pixel |
| in_hsync | input | 1 | Horizontal sync, delayed with the pixel |
| in_vsync | input | 1 | Vertical sync, delayed with the pixel |
| cur_en | input | 1 | Cursor enable |
| gfx_mode | input | 1 | 1 when the display is in a VGA/extended graphics mode |
| x11_mode | input | 1 | Code mapping select: 0 Windows style, 1 X11 style |
| org_x | input | 11 | Cursor left column |
| org_y | input | 11 | Cursor top line |
| base_addr | input | 13 | Pattern base in 1024-byte units |
| off_x | input | 6 | First pattern column shown |
| off_y | input | 6 | First pattern row shown |
| fg_col | input | 8 | Foreground colour |
| bg_col | input | 8 | Background colour |
| line_go | input | 1 | Line start strobe; ignored while a fetch runs |
| line_y | input | 11 | Raster line about to be displayed |
| fetch_busy | output | 1 | A pattern line fetch is in progress |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 20 | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Read data byte |
| out_valid | output | 1 | Delayed pixel strobe |
| out_pix | output | 8 | Output pixel |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_late | output | 1 | Fetch missed the first cursor column of this line |

## Verification
The properties rely on the memory returning exactly one byte per accepted request, in request order, and never returning data without a prior request. The bench's memory model keeps to this with a queue of accepted addresses, and it inserts ready stalls on a fixed pattern. They also rely on `in_valid` being low while reset is held, and on `line_go` arriving only between active lines. The stimulus holds all pixel inputs at zero until reset is released. It issues each line strobe before driving that line's pixels and, except in the deliberate late case, waits for `fetch_busy` to fall first.

// File: rtl/cur_ovl_pkg.sv
package cur_ovl_pkg;

  typedef logic [7:0] pix_t;

  typedef enum logic [1:0] {
    AB_00 = 2'b00,
    AB_01 = 2'b01,
    AB_10 = 2'b10,
    AB_11 = 2'b11
  } ab_code_e;

  // Select the output pixel for one cursor code in either mapping mode.
  function automatic pix_t mix_pixel(input ab_code_e code, input logic x11,
                                     input pix_t scr, input pix_t fg, input pix_t bg);
    pix_t r;
    if (x11) begin
      unique case (code)
        AB_10:   r = bg;
        AB_11:   r = fg;
        default: r = scr;
      endcase
    end else begin
      unique case (code)
        AB_00:   r = bg;
        AB_01:   r = fg;
        AB_10:   r = scr;
        default: r = ~scr;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/cur_line_fetch.sv
module cur_line_fetch
  import cur_ovl_pkg::*;
#(
  parameter int COORD_W = 11,
  parameter int ADDR_W  = 20,
  parameter int BASE_W  = 13,
  parameter int DIM     = 64,
  localparam int OFF_W      = $clog2(DIM),
  localparam int LINE_BYTES = DIM / 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              line_go,
  input  logic [COORD_W-1:0]                line_y,
  input  logic [COORD_W-1:0]                org_y,
  input  logic [BASE_W-1:0]                 base_addr,
  input  logic [OFF_W-1:0]                  off_y,
  input  logic                              cur_on,
  input  logic                              late_now,
  output logic                              busy,
  output logic                              line_hit,
  output logic [LINE_BYTES-1:0][7:0]        act_line,
  output logic                              mem_req_valid,
  input  logic                              mem_req_ready,
  output logic [ADDR_W-1:0]                 mem_req_addr,
  input  logic                              mem_rsp_valid,
  input  logic [7:0]                        mem_rsp_data
);

  localparam int IDX_W    = $clog2(LINE_BYTES);
  localparam int CNT_W    = IDX_W + 1;
  localparam int KB_SHIFT = 10;

  logic                       busy_q, hit_q, drop_q;
  logic [CNT_W-1:0]           req_cnt_q, rsp_cnt_q;
  logic [ADDR_W-1:0]          line_addr_q;
  logic [LINE_BYTES-1:0][7:0] stage_q, stage_d, act_q;

  logic [COORD_W:0]  dy;
  logic [OFF_W:0]    row_lim;
  logic              row_hit;
  logic [OFF_W-1:0]  row;
  logic [ADDR_W-1:0] start_addr;
  logic              accept, req_fire, last_byte;

  always_comb begin
    dy         = {1'b0, line_y} - {1'b0, org_y};
    row_lim    = (OFF_W+1)'(DIM) - {1'b0, off_y};
    row_hit    = cur_on && !dy[COORD_W] && (dy[COORD_W-1:0] < COORD_W'(row_lim));
    row        = dy[OFF_W-1:0] + off_y;
    start_addr = (ADDR_W'(base_addr) << KB_SHIFT) + (ADDR_W'(row) << IDX_W);
  end

  assign accept        = line_go && !busy_q;
  assign mem_req_valid = busy_q && (req_cnt_q < CNT_W'(LINE_BYTES));
  assign mem_req_addr  = line_addr_q + ADDR_W'(req_cnt_q);
  assign req_fire      = mem_req_valid && mem_req_ready;
  assign last_byte     = busy_q && mem_rsp_valid && (rsp_cnt_q == CNT_W'(LINE_BYTES - 1));

  always_comb begin
    stage_d = stage_q;
    if (busy_q && mem_rsp_valid) stage_d[rsp_cnt_q[IDX_W-1:0]] = mem_rsp_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      hit_q       <= 1'b0;
      drop_q      <= 1'b0;
      req_cnt_q   <= '0;
      rsp_cnt_q   <= '0;
      line_addr_q <= '0;
      stage_q     <= '0;
      act_q       <= '0;
    end else if (accept) begin
      hit_q       <= row_hit;
      busy_q      <= row_hit;
      drop_q      <= 1'b0;
      req_cnt_q   <= '0;
      rsp_cnt_q   <= '0;
      line_addr_q <= start_addr;
    end else if (busy_q) begin
      if (req_fire)      req_cnt_q <= req_cnt_q + 1'b1;
      if (mem_rsp_valid) rsp_cnt_q <= rsp_cnt_q + 1'b1;
      if (late_now)      drop_q    <= 1'b1;
      stage_q <= stage_d;
      if (last_byte) begin
        busy_q <= 1'b0;
        if (!(drop_q || late_now)) act_q <= stage_d;
      end
    end
  end

  assign busy     = busy_q;
  assign line_hit = hit_q;
  assign act_line = act_q;

endmodule

// File: rtl/cur_pixel_mix.sv
module cur_pixel_mix
  import cur_ovl_pkg::*;
#(
  parameter int COORD_W = 11,
  parameter int DIM     = 64,
  localparam int OFF_W      = $clog2(DIM),
  localparam int LINE_BYTES = DIM / 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [COORD_W-1:0]         in_x,
  input  pix_t                       in_pix,
  input  logic                       in_hsync,
  input  logic                       in_vsync,
  input  logic                       cur_on,
  input  logic                       x11_mode,
  input  logic [COORD_W-1:0]         org_x,
  input  logic [OFF_W-1:0]           off_x,
  input  pix_t                       fg_col,
  input  pix_t                       bg_col,
  input  logic                       line_hit,
  input  logic                       fetch_busy,
  input  logic [LINE_BYTES-1:0][7:0] act_line,
  output logic                       late_now,
  output logic                       out_valid,
  output pix_t                       out_pix,
  output logic                       out_hsync,
  output logic                       out_vsync,
  output logic                       out_late
);

  localparam int GROUPS = DIM / 16;
  localparam int GRP_W  = OFF_W - 4;

  logic [GROUPS-1:0][15:0] a_word, b_word;

  for (genvar g = 0; g < GROUPS; g++) begin : g_words
    assign a_word[g] = {act_line[4*g],     act_line[4*g + 1]};
    assign b_word[g] = {act_line[4*g + 2], act_line[4*g + 3]};
  end

  logic [COORD_W:0] dx;
  logic [OFF_W:0]   col_lim;
  logic             col_hit, ovl;
  logic [OFF_W-1:0] col;
  logic [GRP_W-1:0] grp;
  logic [3:0]       bsel;
  ab_code_e         code;
  pix_t             mixed;

  always_comb begin
    dx      = {1'b0, in_x} - {1'b0, org_x};
    col_lim = (OFF_W+1)'(DIM) - {1'b0, off_x};
    col_hit = !dx[COORD_W] && (dx[COORD_W-1:0] < COORD_W'(col_lim));
    col     = dx[OFF_W-1:0] + off_x;
    grp     = col[OFF_W-1:4];
    bsel    = ~col[3:0];
    code    = ab_code_e'({a_word[grp][bsel], b_word[grp][bsel]});
    mixed   = mix_pixel(code, x11_mode, in_pix, fg_col, bg_col);
    ovl     = in_valid && cur_on && line_hit && col_hit;
  end

  assign late_now = ovl && (dx == '0) && fetch_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_hsync <= 1'b0;
      out_vsync <= 1'b0;
      out_late  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_pix   <= ovl ? mixed : in_pix;
      out_hsync <= in_hsync;
      out_vsync <= in_vsync;
      out_late  <= late_now;
    end
  end

endmodule

// File: rtl/cur_overlay.sv
module cur_overlay
  import cur_ovl_pkg::*;
#(
  parameter int COORD_W = 11,
  parameter int ADDR_W  = 20,
  parameter int BASE_W  = 13,
  parameter int DIM     = 64,
  localparam int OFF_W      = $clog2(DIM),
  localparam int LINE_BYTES = DIM / 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [COORD_W-1:0] in_x,
  input  logic [7:0]         in_pix,
  input  logic               in_hsync,
  input  logic               in_vsync,
  input  logic               cur_en,
  input  logic               gfx_mode,
  input  logic               x11_mode,
  input  logic [COORD_W-1:0] org_x,
  input  logic [COORD_W-1:0] org_y,
  input  logic [BASE_W-1:0]  base_addr,
  input  logic [OFF_W-1:0]   off_x,
  input  logic [OFF_W-1:0]   off_y,
  input  logic [7:0]         fg_col,
  input  logic [7:0]         bg_col,
  input  logic               line_go,
  input  logic [COORD_W-1:0] line_y,
  output logic               fetch_busy,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [7:0]         mem_rsp_data,
  output logic               out_valid,
  output logic [7:0]         out_pix,
  output logic               out_hsync,
  output logic               out_vsync,
  output logic               out_late
);

  logic                       cur_on, line_hit, late_now;
  logic [LINE_BYTES-1:0][7:0] act_line;

  assign cur_on = cur_en && gfx_mode;

  cur_line_fetch #(
    .COORD_W(COORD_W), .ADDR_W(ADDR_W), .BASE_W(BASE_W), .DIM(DIM)
  ) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_go      (line_go),
    .line_y       (line_y),
    .org_y        (org_y),
    .base_addr    (base_addr),
    .off_y        (off_y),
    .cur_on       (cur_on),
    .late_now     (late_now),
    .busy         (fetch_busy),
    .line_hit     (line_hit),
    .act_line     (act_line),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data)
  );

  cur_pixel_mix #(
    .COORD_W(COORD_W), .DIM(DIM)
  ) u_mix (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_x      (in_x),
    .in_pix    (in_pix),
    .in_hsync  (in_hsync),
    .in_vsync  (in_vsync),
    .cur_on    (cur_on),
    .x11_mode  (x11_mode),
    .org_x     (org_x),
    .off_x     (off_x),
    .fg_col    (fg_col),
    .bg_col    (bg_col),
    .line_hit  (line_hit),
    .fetch_busy(fetch_busy),
    .act_line  (act_line),
    .late_now  (late_now),
    .out_valid (out_valid),
    .out_pix   (out_pix),
    .out_hsync (out_hsync),
    .out_vsync (out_vsync),
    .out_late  (out_late)
  );

endmodule

// File: rtl/cur_overlay_chk.sv
module cur_overlay_chk #(
  parameter int ADDR_W = 20,
  parameter int DIM    = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [7:0]        in_pix,
  input logic              cur_en,
  input logic              line_go,
  input logic              fetch_busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              out_valid,
  input logic [7:0]        out_pix,
  input logic              out_late
);

  localparam int LINE_BYTES = DIM / 4;
  localparam int CNT_W      = $clog2(LINE_BYTES + 1) + 1;

  logic [CNT_W-1:0] acc_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                        acc_cnt <= '0;
    else if (line_go && !fetch_busy)   acc_cnt <= '0;
    else if (mem_req_valid && mem_req_ready) acc_cnt <= acc_cnt + 1'b1;
  end

  // R9
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R6
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cur_en) |=> (out_pix == $past(in_pix)));

  // R2
  req_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (acc_cnt < CNT_W'(LINE_BYTES)));

  // R2
  rsp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> fetch_busy);

  // R10
  late_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_late |-> $past(fetch_busy));

endmodule

bind cur_overlay cur_overlay_chk #(.ADDR_W(ADDR_W), .DIM(DIM)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_pix       (in_pix),
  .cur_en       (cur_en),
  .line_go      (line_go),
  .fetch_busy   (fetch_busy),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid),
  .out_valid    (out_valid),
  .out_pix      (out_pix),
  .out_late     (out_late)
);

// File: tb/cur_overlay_tb.sv
module cur_overlay_tb;

  localparam int ADDR_W = 20;
  localparam int NPIX   = 100;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        in_valid = 0, in_hsync = 0, in_vsync = 0;
  logic [10:0] in_x = '0;
  logic [7:0]  in_pix = '0;
  logic        cur_en = 0, gfx_mode = 0, x11_mode = 0;
  logic [10:0] org_x = '0, org_y = '0, line_y = '0;
  logic [12:0] base_addr = '0;
  logic [5:0]  off_x = '0, off_y = '0;
  logic [7:0]  fg_col = '0, bg_col = '0;
  logic        line_go = 0;
  logic        fetch_busy, mem_req_valid, mem_rsp_valid = 0, mem_req_ready = 0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [7:0]  mem_rsp_data = '0;
  logic        out_valid, out_hsync, out_vsync, out_late;
  logic [7:0]  out_pix;

  cur_overlay u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_pix(in_pix),
    .in_hsync(in_hsync), .in_vsync(in_vsync), .cur_en(cur_en), .gfx_mode(gfx_mode),
    .x11_mode(x11_mode), .org_x(org_x), .org_y(org_y), .base_addr(base_addr),
    .off_x(off_x), .off_y(off_y), .fg_col(fg_col), .bg_col(bg_col),
    .line_go(line_go), .line_y(line_y), .fetch_busy(fetch_busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .out_valid(out_valid), .out_pix(out_pix),
    .out_hsync(out_hsync), .out_vsync(out_vsync), .out_late(out_late)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  typedef struct packed {
    logic [7:0] pix;
    logic       late;
    logic       hs;
    logic       vs;
    logic [3:0] tag;
  } exp_t;

  exp_t              exp_q[$];
  logic [ADDR_W-1:0] addr_q[$];
  logic [ADDR_W-1:0] pend_q[$];
  logic [7:0]        act_m[16];
  bit                hit_m, late_m;
  logic              prev_in_valid = 0;
  logic              prev_stall = 0;
  logic [ADDR_W-1:0] prev_addr = '0;

  function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd37;
    return t ^ a[15:8] ^ {4'h0, a[19:16]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Memory model: ready stalls every third cycle, one byte back per accepted read.
  initial begin
    int n = 0;
    forever begin
      @(posedge clk);
      #1;
      n++;
      mem_req_ready = (n % 3) != 1;
      if (pend_q.size() > 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_byte(pend_q.pop_front());
      end else begin
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // Monitor at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        check(out_valid == prev_in_valid, "R9", out_valid, prev_in_valid);
        if (prev_stall)
          check(mem_req_valid && (mem_req_addr == prev_addr), "R3", mem_req_addr, prev_addr);
        if (mem_req_valid && mem_req_ready) begin
          if (addr_q.size() == 0) check(0, "R2", mem_req_addr, 0);
          else begin
            logic [ADDR_W-1:0] ea;
            ea = addr_q.pop_front();
            check(mem_req_addr == ea, "R2", mem_req_addr, ea);
          end
          pend_q.push_back(mem_req_addr);
        end
        if (out_valid) begin
          if (exp_q.size() == 0) check(0, "R9", out_pix, 0);
          else begin
            exp_t e;
            string r;
            e = exp_q.pop_front();
            case (e.tag)
              4'd4: r = "R4";
              4'd5: r = "R5";
              4'd6: r = "R6";
              default: r = "R7";
            endcase
            check(out_pix == e.pix, r, out_pix, e.pix);
            check(out_late == e.late, "R10", out_late, e.late);
            check({out_hsync, out_vsync} == {e.hs, e.vs}, "R9", {out_hsync, out_vsync}, {e.hs, e.vs});
          end
        end
      end
      prev_in_valid = in_valid;
      prev_stall    = mem_req_valid && !mem_req_ready;
      prev_addr     = mem_req_addr;
    end
  end

  task automatic start_line(input int y);
    int dy, row;
    dy    = y - int'(org_y);
    hit_m = cur_en && gfx_mode && dy >= 0 && dy < 64 - int'(off_y);
    row   = dy + int'(off_y);
    if (hit_m)
      for (int k = 0; k < 16; k++)
        addr_q.push_back(ADDR_W'((int'(base_addr) * 1024 + row * 16 + k) & ((1 << ADDR_W) - 1)));
    line_y  = 11'(y);
    line_go = 1'b1;
    tick();
    line_go = 1'b0;
  endtask

  task automatic finish_fetch(input int y, input bit keep);
    int row;
    while (fetch_busy) tick();
    row = y - int'(org_y) + int'(off_y);
    if (hit_m && keep)
      for (int k = 0; k < 16; k++)
        act_m[k] = mem_byte(ADDR_W'((int'(base_addr) * 1024 + row * 16 + k) & ((1 << ADDR_W) - 1)));
  endtask

  task automatic drive_line(input int y);
    for (int x = 0; x < NPIX; x++) begin
      exp_t e;
      int dx, c, g, b;
      logic [15:0] aw, bw;
      logic [7:0] scr;
      scr = 8'((x * 7 + y * 3) ^ (x >> 2));
      in_valid = 1'b1;
      in_x     = 11'(x);
      in_pix   = scr;
      in_hsync = (x % 8) < 3;
      in_vsync = (x == 5);
      dx = x - int'(org_x);
      e.hs = in_hsync;
      e.vs = in_vsync;
      e.late = 1'b0;
      e.pix = scr;
      if (!cur_en || !gfx_mode) e.tag = 4'd6;
      else if (!(hit_m && dx >= 0 && dx < 64 - int'(off_x))) e.tag = 4'd7;
      else begin
        // R8: A word from bytes 4g/4g+1, B word from 4g+2/4g+3, pixel j on bit 15-j
        c  = dx + int'(off_x);
        g  = c / 16;
        b  = 15 - (c % 16);
        aw = {act_m[4*g], act_m[4*g+1]};
        bw = {act_m[4*g+2], act_m[4*g+3]};
        e.tag  = x11_mode ? 4'd5 : 4'd4;
        e.late = late_m && (dx == 0);
        case ({aw[b], bw[b]})
          2'b00: e.pix = x11_mode ? scr : bg_col;
          2'b01: e.pix = x11_mode ? scr : fg_col;
          2'b10: e.pix = x11_mode ? bg_col : scr;
          default: e.pix = x11_mode ? fg_col : ~scr;
        endcase
      end
      exp_q.push_back(e);
      tick();
    end
    in_valid = 1'b0;
    in_hsync = 1'b0;
    in_vsync = 1'b0;
    repeat (3) tick();
  endtask

  task automatic full_line(input int y);
    start_line(y);
    finish_fetch(y, 1'b1);
    drive_line(y);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) act_m[k] = 8'h00;
    late_m = 0;
    repeat (3) tick();
    @(negedge clk);
    // R1 reset state
    check(!out_valid && !out_late, "R1", {out_valid, out_late}, 0);
    check(!mem_req_valid && !fetch_busy, "R1", {mem_req_valid, fetch_busy}, 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    tick();

    // R4/R8 Windows mapping, rectangle rows around the top edge
    cur_en = 1; gfx_mode = 1; x11_mode = 0;
    org_x = 11'd20; org_y = 11'd5; base_addr = 13'd3;
    fg_col = 8'hA5; bg_col = 8'h3C;
    for (int y = 4; y < 9; y++) full_line(y);

    // R5 X11 mapping
    x11_mode = 1;
    for (int y = 5; y < 8; y++) full_line(y);

    // R7 offsets and bottom/right edges
    x11_mode = 0; org_x = 11'd30; org_y = 11'd100; off_x = 6'd10; off_y = 6'd60;
    for (int y = 99; y < 105; y++) full_line(y);
    off_x = 6'd0; off_y = 6'd0;

    // R6 disabled, then non-graphics mode
    cur_en = 0;
    full_line(110);
    cur_en = 1; gfx_mode = 0;
    full_line(110);
    gfx_mode = 1;

    // R2 address wrap at the top of memory
    base_addr = 13'd1026; org_y = 11'd300; org_x = 11'd40;
    full_line(301);

    // R10 late fetch keeps previous row
    org_x = 11'd0; org_y = 11'd200; base_addr = 13'd7;
    full_line(200);
    start_line(201);
    late_m = 1;
    drive_line(201);
    late_m = 0;
    finish_fetch(201, 1'b0);
    full_line(202);

    repeat (5) tick();
    check(exp_q.size() == 0, "R9", exp_q.size(), 0);
    check(addr_q.size() == 0, "R2", addr_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule